// File: doc/BRIEF.md
# SDRAM Command and Power-State Tracker

This block sits on the device side of an SDRAM control bus and follows, one clock at a time, what the memory would be doing. Each cycle it samples the clock-enable line, chip select, the three command strobes, a two-bit bank selector and a 14-bit address. It decodes the command, keeps a flag per bank saying whether a row is open, and keeps a power state: running, clock-suspended, self-refreshing or powered down. The previous clock-enable sample is held inside the block. Together with the current sample, the command and the present state, it decides every power-state change.

The block also holds a copy of the mode register and remembers whether that register has been loaded since reset. Commands that are not allowed in the present state, or that come before the mode register is loaded, raise a one-cycle error pulse and change nothing. All outputs are registered and reflect the command sampled at the previous rising edge. The outputs are the mode code, the bank-open vector, the decoded command code, the error pulse, the row latched by the most recent activate, and the mode register with its valid flag.

Top module: `sdram_state_tracker`

## Requirements
- R1: While `rstN` is low at a rising edge, all banks are closed, mode is idle (0), command code is 0, error is low, `actRow` and `modeReg` are 0, `modeValid` is low, and the previous clock-enable sample is taken as high.
- R2: An activate (chip select low; RAS, CAS, WE = L,H,H) with both clock-enable samples high and the mode register loaded sets `bankOpen[bankSel]` (selector 0..3 picks bit 0..3), latches `addr[11:0]` into `actRow`, and moves the mode to active (1).
- R3: A precharge (L,H,L) with `addr[10]` low closes only the selected bank, and the mode returns to idle (0) once no bank is open.
- R4: A precharge with `addr[10]` high closes all four banks.
- R5: A mode-register-set (L,L,L) with no bank open loads `addr` into `modeReg` and raises `modeValid`. With any bank open it raises the error pulse and leaves the register unchanged.
- R6: With a bank open, clock enable high on the previous sample and low on the current one enters clock suspend (mode 2) and ignores the command. The block stays suspended while clock enable stays low and returns to active when it is sampled high.
- R7: In idle, with both clock-enable samples high, the refresh encoding (L,L,H) yields command code 6 and leaves the mode idle.
- R8: In idle, the refresh encoding given while clock enable falls enters self-refresh (mode 3) with command code 7. Clock enable sampled high returns the block to idle.
- R9: In idle, clock enable falling with chip select high or a no-operation (H,H,H) enters power-down (mode 4). Clock enable sampled high returns the block to idle.
- R10: A command has an effect only when both clock-enable samples are high. In the other cycles, including each low-power exit cycle and a falling edge in idle with any other command, the command code is 0 and no bank or register changes.
- R11: An activate, refresh or self-refresh before the mode register is loaded, or a refresh with any bank open, raises the error pulse for that one cycle and has no other effect.
- R12: A read (H,L,H) or write (H,L,L) to a bank that is not open raises the error pulse.
- R13: Command codes: 0 none/no-op/deselect, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all, 6 refresh, 7 self-refresh entry, 8 mode-register-set, 9 burst stop (H,H,L). An erroneous command still reports its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable sample of this cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | 2 | Bank selector |
| addr | input | 14 | Address bus |
| mode | output | 3 | 0 idle, 1 active, 2 suspend, 3 self-refresh, 4 power-down |
| bankOpen | output | 4 | One bit per bank, high when open |
| cmdCode | output | 4 | Decoded command of the previous cycle |
| errPulse | output | 1 | High for one cycle after an illegal command |
| actRow | output | 12 | Row latched by the latest activate |
| modeReg | output | 14 | Loaded mode register contents |
| modeValid | output | 1 | Mode register has been loaded |

## Verification
Every output comes from a single register stage, so each result is due at the first rising edge after the cycle in which its inputs are presented. State changes that depend on the previous clock-enable sample fall in the same cycle, because that sample is already held inside the block. The driver changes inputs on the falling edge and queues the expected outputs, stamped with the number of the next rising edge. The monitor compares an item only at the falling edge whose cycle count equals that stamp, half a period after the register updates and away from the active edge.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_ACTIVE  = 3'd1,
    MODE_SUSPEND = 3'd2,
    MODE_SELFREF = 3'd3,
    MODE_PWRDN   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SUSP = 2'd1,
    ST_SREF = 2'd2,
    ST_PDN  = 2'd3
  } pstate_e;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_READ  = 4'd2,
    CMD_WRITE = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_PALL  = 4'd5,
    CMD_REF   = 4'd6,
    CMD_SELF  = 4'd7,
    CMD_MRS   = 4'd8,
    CMD_BST   = 4'd9
  } cmd_e;

  typedef struct packed {
    logic openBank;
    logic closeOne;
    logic closeAll;
    logic loadMode;
  } strobe_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 allBit,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 programmed,
  output strobe_t              strb,
  output mode_e                mode,
  output cmd_e                 cmdCode,
  output logic                 errPulse
);

  logic    ckeLast;
  pstate_e pState, pNext;
  cmd_e    decoded, cmdNext;
  logic    errNext;
  strobe_t strbC;
  logic    anyOpen, selOpen, bothHigh, falling;

  assign anyOpen  = |bankOpen;
  assign selOpen  = bankOpen[bankSel];
  assign bothHigh = ckeLast && cke;
  assign falling  = ckeLast && !cke;

  always_comb begin
    if (csN) begin
      decoded = CMD_NONE;
    end else begin
      case ({rasN, casN, weN})
        3'b011:  decoded = CMD_ACT;
        3'b101:  decoded = CMD_READ;
        3'b100:  decoded = CMD_WRITE;
        3'b010:  decoded = allBit ? CMD_PALL : CMD_PRE;
        3'b001:  decoded = CMD_REF;
        3'b000:  decoded = CMD_MRS;
        3'b110:  decoded = CMD_BST;
        default: decoded = CMD_NONE;
      endcase
    end
  end

  always_comb begin
    pNext   = pState;
    cmdNext = CMD_NONE;
    errNext = 1'b0;
    strbC   = '0;
    case (pState)
      ST_RUN: begin
        if (falling) begin
          if (anyOpen) begin
            pNext = ST_SUSP;
          end else if (decoded == CMD_REF) begin
            cmdNext = CMD_SELF;
            if (!programmed) errNext = 1'b1;
            else             pNext   = ST_SREF;
          end else if (decoded == CMD_NONE) begin
            pNext = ST_PDN;
          end
        end else if (bothHigh) begin
          cmdNext = decoded;
          case (decoded)
            CMD_ACT: begin
              if (!programmed) errNext = 1'b1;
              else             strbC.openBank = 1'b1;
            end
            CMD_READ, CMD_WRITE: errNext = !selOpen;
            CMD_PRE:  strbC.closeOne = 1'b1;
            CMD_PALL: strbC.closeAll = 1'b1;
            CMD_REF:  errNext = !programmed || anyOpen;
            CMD_MRS: begin
              if (anyOpen) errNext = 1'b1;
              else         strbC.loadMode = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: begin
        if (cke) pNext = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeLast  <= 1'b1;
      pState   <= ST_RUN;
      cmdCode  <= CMD_NONE;
      errPulse <= 1'b0;
    end else begin
      ckeLast  <= cke;
      pState   <= pNext;
      cmdCode  <= cmdNext;
      errPulse <= errNext;
    end
  end

  assign strb = strbC;

  always_comb begin
    case (pState)
      ST_SUSP: mode = MODE_SUSPEND;
      ST_SREF: mode = MODE_SELFREF;
      ST_PDN:  mode = MODE_PWRDN;
      default: mode = anyOpen ? MODE_ACTIVE : MODE_IDLE;
    endcase
  end

  // R6: suspension holds while clock enable stays low
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pState == ST_SUSP && !cke) |=> (pState == ST_SUSP));

  // R8 / R9: low-power states leave when clock enable returns high
  p_lowpower_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((pState == ST_SREF || pState == ST_PDN) && cke) |=> (pState == ST_RUN));

  // R10: nothing is executed outside the running state
  p_quiet_lowpower_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pState != ST_RUN) |-> (strbC == '0));

  p_no_code_lowpower_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pState != ST_RUN) |=> (cmdCode == CMD_NONE));

  // R11: a bank is never opened before the mode register is loaded
  p_act_needs_prog_r11: assert property (@(posedge clk) disable iff (!rstN)
    strbC.openBank |-> programmed);

endmodule

// File: rtl/sdram_trk_dp.sv
module sdram_trk_dp
  import sdram_trk_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 12,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [ROW_W-1:0]     actRow,
  output logic [ADDR_W-1:0]    modeReg,
  output logic                 programmed
);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic hit;
    assign hit = (bankSel == BANK_BITS'(gb));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[gb] <= 1'b0;
      end else if (strb.closeAll || (strb.closeOne && hit)) begin
        bankOpen[gb] <= 1'b0;
      end else if (strb.openBank && hit) begin
        bankOpen[gb] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actRow     <= '0;
      modeReg    <= '0;
      programmed <= 1'b0;
    end else begin
      if (strb.openBank) actRow <= addr[ROW_W-1:0];
      if (strb.loadMode) begin
        modeReg    <= addr;
        programmed <= 1'b1;
      end
    end
  end

  // R2: activate opens the chosen bank and captures the row
  p_open_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.openBank |=> (bankOpen[$past(bankSel)] && actRow == $past(addr[ROW_W-1:0])));

  // R3: single precharge never opens anything and closes the chosen bank
  p_close_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeOne |=> (!bankOpen[$past(bankSel)] && ((bankOpen & ~$past(bankOpen)) == '0)));

  // R4: precharge-all empties the vector
  p_close_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeAll |=> (bankOpen == '0));

  // R5: mode load takes the address bus
  p_load_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMode |=> (programmed && modeReg == $past(addr)));

endmodule

// File: rtl/sdram_state_tracker.sv
module sdram_state_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 12,
  parameter int ALL_BIT   = 10,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic [ADDR_W-1:0]    addr,
  output logic [2:0]           mode,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [3:0]           cmdCode,
  output logic                 errPulse,
  output logic [ROW_W-1:0]     actRow,
  output logic [ADDR_W-1:0]    modeReg,
  output logic                 modeValid
);

  strobe_t strb;
  mode_e   modeC;
  cmd_e    cmdC;

  sdram_trk_ctrl #(.BANK_BITS(BANK_BITS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .allBit     (addr[ALL_BIT]),
    .bankSel    (bankSel),
    .bankOpen   (bankOpen),
    .programmed (modeValid),
    .strb       (strb),
    .mode       (modeC),
    .cmdCode    (cmdC),
    .errPulse   (errPulse)
  );

  sdram_trk_dp #(
    .BANK_BITS (BANK_BITS),
    .ADDR_W    (ADDR_W),
    .ROW_W     (ROW_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bankSel    (bankSel),
    .addr       (addr),
    .bankOpen   (bankOpen),
    .actRow     (actRow),
    .modeReg    (modeReg),
    .programmed (modeValid)
  );

  assign mode    = modeC;
  assign cmdCode = cmdC;

endmodule

// File: tb/test_sdram_state_tracker.sv
`timescale 1ns/1ps
module test_sdram_state_tracker;

  localparam logic [3:0] P_DESL = 4'b1111;
  localparam logic [3:0] P_NOP  = 4'b0111;
  localparam logic [3:0] P_ACT  = 4'b0011;
  localparam logic [3:0] P_RD   = 4'b0101;
  localparam logic [3:0] P_WR   = 4'b0100;
  localparam logic [3:0] P_PRE  = 4'b0010;
  localparam logic [3:0] P_REF  = 4'b0001;
  localparam logic [3:0] P_MRS  = 4'b0000;
  localparam logic [3:0] P_BST  = 4'b0110;

  logic clk = 1'b0;
  logic rstN, cke, csN, rasN, casN, weN;
  logic [1:0]  bankSel;
  logic [13:0] addr;
  logic [2:0]  mode;
  logic [3:0]  bankOpen, cmdCode;
  logic        errPulse, modeValid;
  logic [11:0] actRow;
  logic [13:0] modeReg;

  always #10 clk = ~clk;

  sdram_state_tracker i_sdram_state_tracker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .addr(addr), .mode(mode), .bankOpen(bankOpen),
    .cmdCode(cmdCode), .errPulse(errPulse), .actRow(actRow), .modeReg(modeReg),
    .modeValid(modeValid)
  );

  typedef struct {
    logic [2:0]  mode;
    logic [3:0]  bank;
    logic [3:0]  code;
    logic        err;
    logic [11:0] row;
    logic [13:0] mreg;
    logic        valid;
    string       tag;
    int          due;
  } exp_t;

  exp_t sbq[$];
  int cycle = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [3:0]  mBank = '0;
  int          mSt = 0;
  logic        mProg = 0;
  logic [13:0] mMreg = '0;
  logic [11:0] mRow = '0;
  logic        mCke = 1'b1;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic int decodeCmd(input logic [3:0] p, input logic a10);
    if (p[3]) return 0;
    case (p[2:0])
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return a10 ? 5 : 4;
      3'b001: return 6;
      3'b000: return 8;
      3'b110: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic step(input logic c, input logic [3:0] p, input logic [1:0] b,
                      input logic [13:0] a, input string tag);
    exp_t e;
    int d;
    logic prevC;
    logic anyOpen;
    @(negedge clk);
    cke = c; {csN, rasN, casN, weN} = p; bankSel = b; addr = a;
    prevC = mCke;
    anyOpen = |mBank;
    d = decodeCmd(p, a[10]);
    e.code = 0; e.err = 0;
    if (mSt != 0) begin
      if (c) mSt = 0;
    end else if (prevC && !c) begin
      if (anyOpen) mSt = 1;
      else if (d == 6) begin
        e.code = 7;
        if (!mProg) e.err = 1; else mSt = 2;
      end else if (d == 0) mSt = 3;
    end else if (prevC && c) begin
      e.code = 4'(d);
      case (d)
        1: if (!mProg) e.err = 1; else begin mBank[b] = 1'b1; mRow = a[11:0]; end
        2, 3: e.err = !mBank[b];
        4: mBank[b] = 1'b0;
        5: mBank = '0;
        6: e.err = !mProg || anyOpen;
        8: if (anyOpen) e.err = 1; else begin mMreg = a; mProg = 1; end
        default: ;
      endcase
    end
    mCke = c;
    case (mSt)
      1: e.mode = 3'd2;
      2: e.mode = 3'd3;
      3: e.mode = 3'd4;
      default: e.mode = (|mBank) ? 3'd1 : 3'd0;
    endcase
    e.bank = mBank; e.row = mRow; e.mreg = mMreg; e.valid = mProg;
    e.tag = tag;
    e.due = cycle + 1;
    sbq.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() > 0 && sbq[0].due == cycle) begin
      e = sbq.pop_front();
      checks++;
      if (mode !== e.mode || bankOpen !== e.bank || cmdCode !== e.code ||
          errPulse !== e.err || actRow !== e.row || modeReg !== e.mreg ||
          modeValid !== e.valid) begin
        errors++;
        $display("FAIL %s: mode=%0d exp %0d bank=%b exp %b code=%0d exp %0d err=%b exp %b row=%h exp %h mreg=%h exp %h valid=%b exp %b",
                 e.tag, mode, e.mode, bankOpen, e.bank, cmdCode, e.code, errPulse, e.err,
                 actRow, e.row, modeReg, e.mreg, modeValid, e.valid);
      end
    end
  end

  initial begin
    rstN = 1'b0; cke = 1'b1; {csN, rasN, casN, weN} = P_DESL; bankSel = '0; addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (mode !== 3'd0 || bankOpen !== 4'd0 || cmdCode !== 4'd0 || errPulse !== 1'b0 ||
        actRow !== '0 || modeReg !== '0 || modeValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: mode=%0d bank=%b code=%0d err=%b row=%h mreg=%h valid=%b exp all zero",
               mode, bankOpen, cmdCode, errPulse, actRow, modeReg, modeValid);
    end
    rstN = 1'b1;

    step(1, P_ACT, 2'd1, 14'h0010, "R11 act before load");
    step(1, P_REF, 2'd0, 14'h0000, "R11 refresh before load");
    step(0, P_REF, 2'd0, 14'h0000, "R11 self-refresh before load");
    step(1, P_NOP, 2'd0, 14'h0000, "R10 cke rising in idle");
    step(1, P_MRS, 2'd0, 14'h02A5, "R5 load mode");
    step(1, P_REF, 2'd0, 14'h0000, "R7 auto refresh");
    step(1, P_ACT, 2'd0, 14'h0123, "R2 open bank 0");
    step(1, P_ACT, 2'd1, 14'h0ABC, "R2 open bank 1");
    step(1, P_ACT, 2'd2, 14'h0456, "R2 open bank 2");
    step(1, P_ACT, 2'd3, 14'h3FFF, "R2 open bank 3 row mask");
    step(1, P_RD,  2'd2, 14'h0000, "R13 read open bank");
    step(1, P_WR,  2'd0, 14'h0000, "R13 write open bank");
    step(1, P_REF, 2'd0, 14'h0000, "R11 refresh with bank open");
    step(1, P_MRS, 2'd0, 14'h1111, "R5 mode set with bank open");
    step(1, P_PRE, 2'd1, 14'h0000, "R3 close bank 1 only");
    step(0, P_ACT, 2'd1, 14'h0777, "R6 enter suspend");
    step(0, P_PRE, 2'd0, 14'h0400, "R10 suspended, precharge-all ignored");
    step(1, P_PRE, 2'd0, 14'h0400, "R6 leave suspend, command ignored");
    step(1, P_PRE, 2'd0, 14'h0400, "R4 precharge all");
    step(1, P_RD,  2'd0, 14'h0000, "R12 read closed bank");
    step(1, P_WR,  2'd3, 14'h0000, "R12 write closed bank");
    step(1, P_ACT, 2'd2, 14'h0999, "R2 reopen bank 2");
    step(1, P_PRE, 2'd2, 14'h0000, "R3 last bank closed to idle");
    step(1, P_BST, 2'd0, 14'h0000, "R13 burst stop");
    step(0, P_DESL, 2'd0, 14'h0000, "R9 power-down by deselect");
    step(0, P_ACT, 2'd0, 14'h0055, "R10 power-down ignores act");
    step(1, P_MRS, 2'd0, 14'h0033, "R9 power-down exit ignores mode set");
    step(0, P_NOP, 2'd0, 14'h0000, "R9 power-down by no-op");
    step(1, P_NOP, 2'd0, 14'h0000, "R9 power-down exit");
    step(0, P_REF, 2'd0, 14'h0000, "R8 enter self-refresh");
    step(0, P_REF, 2'd0, 14'h0000, "R8 hold self-refresh");
    step(1, P_NOP, 2'd0, 14'h0000, "R8 leave self-refresh");
    step(0, P_ACT, 2'd1, 14'h0042, "R10 falling edge with act ignored");
    step(1, P_NOP, 2'd0, 14'h0000, "R10 rising edge in idle");
    step(1, P_ACT, 2'd3, 14'h0808, "R2 open after low-power");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule